// File: doc/BRIEF.md
# USB Event Interrupt Flag Aggregator

This block gathers single-cycle event pulses from a USB device core and latches them into three flag registers: one for bus-level events (suspend, resume, bus reset, start-of-frame), one for control endpoint 0 together with the IN endpoints, and one for the OUT endpoints. Each flag register has an enable-mask register with the same bit layout. The block combines all flags and masks into a single registered, level-sensitive interrupt request for the CPU.

Software reads and writes these registers through a simple strobe port. Reading a flag register returns its contents and clears it on the same clock edge, so an interrupt handler reads each flag register once and keeps a copy. Mask registers can be read and written. A controller-enable input resets the block when it is low. While it is low, the block ignores events and register writes.

The register port uses plain strobes rather than a valid/ready stream. A read or write is accepted in every cycle in which its strobe is high, and the port has no back-pressure. Read data is held until the next read.

Top module: `usb_irq_agg`

## Requirements
- R1: After reset, all flags read 0, `irq_o` and `reg_rdata_o` are 0, and the mask registers read 0x06 (bus events: suspend and start-of-frame disabled), 0x3F (IN) and 0x3E (OUT).
- R2: The address map is: 0 bus-event flags, 1 IN flags, 2 OUT flags, 4 bus-event mask, 5 IN mask, 6 OUT mask. In the bus-event register, bit 0 is suspend, bit 1 resume, bit 2 bus reset and bit 3 start-of-frame. IN bit 0 is endpoint 0 and IN bits 1..5 are IN endpoints 1..5. OUT bits 1..5 are OUT endpoints 1..5. A pulse sampled on an event input sets its flag bit at that clock edge.
- R3: `irq_o` goes high one clock after some flag and its mask bit are both 1.
- R4: When `reg_rd_i` is sampled high, `reg_rdata_o` shows the addressed register after that edge. If the address is a flag register, all its flags are cleared at that same edge.
- R5: An event pulse sampled on the same edge as a read of its flag register stays set after the read. It is not part of the data returned by that read.
- R6: A flag is set even when its mask bit is 0. A masked flag does not raise `irq_o`, but it can still be read.
- R7: Mask registers return the last value written. Bits with no source read 0: bus-event bits 7..4, IN bits 7..6, and OUT bits 7..6 and bit 0.
- R8: Writes to flag addresses have no effect.
- R9: `irq_o` goes low one clock after the last flag that is both pending and enabled is cleared, whether by a read or by a mask write.
- R10: While `ctrl_en` is low, the block is held in its reset state, masks included, and events and register writes are ignored.
- R11: Reading a mask register leaves it unchanged. Addresses 3 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; low holds the block in reset |
| evt_bus_i | input | 4 | Bus event pulses: suspend, resume, bus reset, start-of-frame |
| evt_in_i | input | 6 | Endpoint 0 and IN endpoint 1..5 event pulses |
| evt_out_i | input | 5 | OUT endpoint 1..5 event pulses (index 1..5) |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Level interrupt request |

## Verification
Directed patterns isolate one rule each:
- A masked pulse with no interrupt separates flag latching from interrupt gating.
- A pulse that coincides with a read of its own register tells a clear-then-set merge apart from a plain clear.
- A mask write that drops the last enabled source, compared with a read that clears it, checks both falling paths of the interrupt.
- A controller-enable drop applied while events and writes are active shows that nothing slips through during the disable.

A long stretch of random pulses, reads, writes and enable drops is then compared against a behavioural model on every clock. This exposes ordering errors between clears, sets and mask updates.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int NUM_EP   = 5;
  localparam int REG_W    = 8;
  localparam int NUM_BANK = 3;
  localparam int ADDR_W   = 3;
  localparam int N_BUSEVT = 4;

  localparam int BANK_BUS = 0;
  localparam int BANK_IN  = 1;
  localparam int BANK_OUT = 2;

  localparam int EVT_SUSPEND = 0;
  localparam int EVT_RESUME  = 1;
  localparam int EVT_BUSRST  = 2;
  localparam int EVT_SOF     = 3;

  localparam logic [REG_W-1:0] ONE_BIT   = REG_W'(1);
  localparam logic [REG_W-1:0] BUS_VALID = REG_W'((1 << N_BUSEVT) - 1);
  localparam logic [REG_W-1:0] BUS_RST   = BUS_VALID & ~(ONE_BIT << EVT_SUSPEND)
                                                     & ~(ONE_BIT << EVT_SOF);
  localparam logic [REG_W-1:0] IN_VALID  = REG_W'((1 << (NUM_EP + 1)) - 1);
  localparam logic [REG_W-1:0] OUT_VALID = IN_VALID & ~ONE_BIT;

  function automatic logic [REG_W-1:0] bank_valid(input int b);
    case (b)
      BANK_BUS: return BUS_VALID;
      BANK_IN:  return IN_VALID;
      default:  return OUT_VALID;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] bank_rst_mask(input int b);
    case (b)
      BANK_BUS: return BUS_RST;
      BANK_IN:  return IN_VALID;
      default:  return OUT_VALID;
    endcase
  endfunction
endpackage

// File: rtl/usb_irq_bank.sv
module usb_irq_bank #(
  parameter int               W        = 8,
  parameter logic [W-1:0]     VALID    = '1,
  parameter logic [W-1:0]     RST_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] evt_i,
  input  logic         rd_flag_i,
  input  logic         wr_mask_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] flags_o,
  output logic [W-1:0] mask_o,
  output logic         pend_o
);
  logic [W-1:0] flags_q, mask_q, flags_nxt, evt_v;

  assign evt_v = evt_i & VALID;

  // Clear on read first, then merge this cycle's events so none is lost.
  always_comb begin
    flags_nxt = rd_flag_i ? '0 : flags_q;
    flags_nxt = flags_nxt | evt_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= RST_MASK;
    end else if (!en_i) begin
      flags_q <= '0;
      mask_q  <= RST_MASK;
    end else begin
      flags_q <= flags_nxt;
      if (wr_mask_i) mask_q <= wdata_i & VALID;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
  assign pend_o  = |(flags_q & mask_q);

  assert_clear_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flag_i && evt_v == '0) |=> (flags_q == '0));

  assert_evt_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && evt_v != '0) |=> ((flags_q & $past(evt_v)) == $past(evt_v)));

  assert_disable_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> (flags_q == '0 && mask_q == RST_MASK));

  assert_mask_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !wr_mask_i) |=> $stable(mask_q));
endmodule

// File: rtl/usb_irq_regport.sv
module usb_irq_regport
  import usb_irq_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en_i,
  input  logic                      rd_i,
  input  logic                      wr_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [NUM_BANK*REG_W-1:0] flags_all_i,
  input  logic [NUM_BANK*REG_W-1:0] masks_all_i,
  output logic [NUM_BANK-1:0]       rd_flag_o,
  output logic [NUM_BANK-1:0]       wr_mask_o,
  output logic [REG_W-1:0]          rdata_o
);
  localparam int IDX_W = ADDR_W - 1;

  logic             is_mask;
  logic [IDX_W-1:0] idx;
  logic [REG_W-1:0] rd_mux;

  assign is_mask = addr_i[ADDR_W-1];
  assign idx     = addr_i[IDX_W-1:0];

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_dec
    assign rd_flag_o[b] = en_i && rd_i && !is_mask && (idx == IDX_W'(b));
    assign wr_mask_o[b] = en_i && wr_i &&  is_mask && (idx == IDX_W'(b));
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANK; b++) begin
      if (idx == IDX_W'(b))
        rd_mux = is_mask ? masks_all_i[b*REG_W +: REG_W] : flags_all_i[b*REG_W +: REG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_o <= '0;
    else if (!en_i)      rdata_o <= '0;
    else if (rd_i)       rdata_o <= rd_mux;
  end

  assert_hole_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && rd_i && int'(idx) >= NUM_BANK) |=> (rdata_o == '0));

  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !rd_i) |=> $stable(rdata_o));
endmodule

// File: rtl/usb_irq_req.sv
module usb_irq_req
  import usb_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en_i,
  input  logic [NUM_BANK-1:0] pend_i,
  output logic                irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     irq_o <= 1'b0;
    else if (!en_i) irq_o <= 1'b0;
    else            irq_o <= |pend_i;
  end

  assert_irq_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && pend_i != '0) |=> irq_o);

  assert_irq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |=> !irq_o);

  assert_irq_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i) |=> !irq_o);
endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_en,
  input  logic [N_BUSEVT-1:0] evt_bus_i,
  input  logic [NUM_EP:0]   evt_in_i,
  input  logic [NUM_EP:1]   evt_out_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  logic [REG_W-1:0]          evt_vec [NUM_BANK];
  logic [NUM_BANK*REG_W-1:0] flags_all, masks_all;
  logic [NUM_BANK-1:0]       rd_flag, wr_mask, pend;

  always_comb begin
    for (int b = 0; b < NUM_BANK; b++) evt_vec[b] = '0;
    evt_vec[BANK_BUS][N_BUSEVT-1:0] = evt_bus_i;
    evt_vec[BANK_IN][NUM_EP:0]      = evt_in_i;
    evt_vec[BANK_OUT][NUM_EP:1]     = evt_out_i;
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    usb_irq_bank #(
      .W        (REG_W),
      .VALID    (bank_valid(b)),
      .RST_MASK (bank_rst_mask(b))
    ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (ctrl_en),
      .evt_i     (evt_vec[b]),
      .rd_flag_i (rd_flag[b]),
      .wr_mask_i (wr_mask[b]),
      .wdata_i   (reg_wdata_i),
      .flags_o   (flags_all[b*REG_W +: REG_W]),
      .mask_o    (masks_all[b*REG_W +: REG_W]),
      .pend_o    (pend[b])
    );
  end

  usb_irq_regport regport_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (ctrl_en),
    .rd_i        (reg_rd_i),
    .wr_i        (reg_wr_i),
    .addr_i      (reg_addr_i),
    .flags_all_i (flags_all),
    .masks_all_i (masks_all),
    .rd_flag_o   (rd_flag),
    .wr_mask_o   (wr_mask),
    .rdata_o     (reg_rdata_o)
  );

  usb_irq_req req_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (ctrl_en),
    .pend_i (pend),
    .irq_o  (irq_o)
  );

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_all & masks_all) == '0) |=> !irq_o);
endmodule

// File: tb/usb_irq_agg_tb_top.sv
module usb_irq_agg_tb_top;
  import usb_irq_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ctrl_en = 1'b1;
  logic [3:0] ev_c = '0;
  logic [5:0] ev_i = '0;
  logic [5:1] ev_o = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  usb_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
    .evt_bus_i(ev_c), .evt_in_i(ev_i), .evt_out_i(ev_o),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  int n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit run_cmp = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int VAL [3] = '{'h0F, 'h3F, 'h3E};
  int RST [3] = '{'h06, 'h3F, 'h3E};
  int m_flg [3];
  int m_msk [3];
  int m_irq = 0, m_rd = 0;
  int ev_m [3];

  always @(posedge clk) begin
    if (!rst_n || !ctrl_en) begin
      for (int b = 0; b < 3; b++) begin m_flg[b] = 0; m_msk[b] = RST[b]; end
      m_irq = 0; m_rd = 0;
    end else begin
      ev_m[0] = int'(ev_c); ev_m[1] = int'(ev_i); ev_m[2] = int'(ev_o) * 2;
      m_irq = (((m_flg[0] & m_msk[0]) | (m_flg[1] & m_msk[1]) | (m_flg[2] & m_msk[2])) != 0) ? 1 : 0;
      if (rd) begin
        if (addr < 3)       m_rd = m_flg[addr];
        else if (addr >= 4 && addr <= 6) m_rd = m_msk[addr - 4];
        else                m_rd = 0;
      end
      for (int b = 0; b < 3; b++)
        m_flg[b] = (((rd && addr == 3'(b)) ? 0 : m_flg[b]) | (ev_m[b] & VAL[b]));
      if (wr && addr >= 4 && addr <= 6) m_msk[addr - 4] = int'(wdata) & VAL[addr - 4];
    end
  end

  always @(negedge clk) begin
    if (run_cmp && rst_n) begin
      check(cur_req, 32'(irq), 32'(m_irq), "irq vs model");
      check(cur_req, 32'(rdata), 32'(m_rd), "rdata vs model");
    end
  end

  task automatic tick;
    @(negedge clk); #1;
  endtask

  task automatic do_read(input logic [2:0] a, input logic [7:0] exp, input string req);
    rd = 1'b1; addr = a; tick; rd = 1'b0;
    check(req, 32'(rdata), 32'(exp), $sformatf("read addr %0d", a));
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d; tick; wr = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    tick; tick; tick;
    check("R1", 32'(irq), 0, "irq in reset");
    check("R1", 32'(rdata), 0, "rdata in reset");
    rst_n = 1'b1; tick;
    run_cmp = 1'b1;
    do_read(3'd4, 8'h06, "R1");
    do_read(3'd5, 8'h3F, "R1");
    do_read(3'd6, 8'h3E, "R1");
    do_read(3'd0, 8'h00, "R1");

    // R6: suspend and start-of-frame pulses are masked at reset
    cur_req = "R6";
    ev_c = 4'b1001; tick; ev_c = '0; tick; tick;
    check("R6", 32'(irq), 0, "masked events keep irq low");
    do_read(3'd0, 8'h09, "R2");
    do_read(3'd0, 8'h00, "R4");

    // R3 / R9: IN endpoint 2
    cur_req = "R3";
    ev_i = 6'b000100; tick; ev_i = '0;
    check("R3", 32'(irq), 0, "irq one edge after event");
    tick;
    check("R3", 32'(irq), 1, "irq raised");
    do_read(3'd1, 8'h04, "R4");
    check("R9", 32'(irq), 1, "irq still high at clear edge");
    tick;
    check("R9", 32'(irq), 0, "irq low after clear by read");

    // R5: coincident event and read
    cur_req = "R5";
    ev_o[1] = 1'b1; tick; ev_o = '0;
    rd = 1'b1; addr = 3'd2; ev_o[3] = 1'b1; tick; rd = 1'b0; ev_o = '0;
    check("R5", 32'(rdata), 32'h02, "read during event");
    do_read(3'd2, 8'h08, "R5");
    tick; tick;

    // R7 / R11: mask access and unused bits
    cur_req = "R7";
    do_write(3'd4, 8'hFF);
    do_read(3'd4, 8'h0F, "R7");
    do_write(3'd6, 8'hFF);
    do_read(3'd6, 8'h3E, "R7");
    do_read(3'd6, 8'h3E, "R11");
    do_write(3'd4, 8'h06);

    // R8: writes to flag registers ignored
    cur_req = "R8";
    ev_c[1] = 1'b1; tick; ev_c = '0;
    do_write(3'd0, 8'h00);
    do_read(3'd0, 8'h02, "R8");
    do_write(3'd1, 8'hFF);
    do_read(3'd1, 8'h00, "R8");
    tick; tick;

    // R9: clearing the mask drops irq
    cur_req = "R9";
    ev_i[0] = 1'b1; tick; ev_i = '0; tick;
    check("R3", 32'(irq), 1, "endpoint 0 irq");
    do_write(3'd5, 8'h00);
    check("R9", 32'(irq), 1, "irq at mask write edge");
    tick;
    check("R9", 32'(irq), 0, "irq low after mask clear");
    do_read(3'd1, 8'h01, "R6");
    do_write(3'd5, 8'h3F);

    // R10: controller disable
    cur_req = "R10";
    do_write(3'd5, 8'h00);
    ev_c = 4'b0110; tick; ev_c = '0; tick;
    check("R10", 32'(irq), 1, "irq before disable");
    ctrl_en = 1'b0; ev_i = '1; wr = 1'b1; addr = 3'd5; wdata = 8'hFF;
    tick; tick;
    check("R10", 32'(irq), 0, "irq while disabled");
    ctrl_en = 1'b1; ev_i = '0; wr = 1'b0; tick;
    do_read(3'd5, 8'h3F, "R10");
    do_read(3'd0, 8'h00, "R10");
    do_read(3'd1, 8'h00, "R10");

    // R11: address holes
    cur_req = "R11";
    do_read(3'd3, 8'h00, "R11");
    do_read(3'd7, 8'h00, "R11");

    // Random traffic against the model
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      ev_c  = (($urandom % 4) == 0) ? 4'($urandom) : '0;
      ev_i  = (($urandom % 4) == 0) ? 6'($urandom) : '0;
      ev_o  = (($urandom % 4) == 0) ? 5'($urandom) : '0;
      rd    = (($urandom % 3) == 0);
      wr    = (($urandom % 5) == 0);
      addr  = 3'($urandom);
      wdata = 8'($urandom);
      ctrl_en = (($urandom % 60) != 0);
      tick;
    end
    ev_c = '0; ev_i = '0; ev_o = '0; rd = 1'b0; wr = 1'b0; ctrl_en = 1'b1;
    tick; tick;

    summary();
    $finish;
  end
endmodule